// File: doc/BRIEF.md
# Restoring Sequential Divider

A multicycle integer divider that works out a quotient and a remainder one bit per clock by restoring long division. The running remainder starts out as the dividend magnitude, held in a register twice the operand width. The divisor magnitude starts in the upper half of a second register of the same width. On every step the divisor is trial-subtracted from the remainder. A non-negative difference is kept and shifts a 1 into the quotient. A negative difference leaves the remainder untouched and shifts in a 0. The divisor then moves right by one bit. The loop runs operand width plus one times.

A mode input selects unsigned or two's complement operands. In signed mode the divider notes the sign of each result first, divides the magnitudes as unsigned numbers, and then negates the results where needed. The quotient rounds toward zero. A zero divisor is caught when the request is accepted: the operation ends at once and a flag is raised. A request is started with a one-cycle `start`. The `busy` output is high while the operation runs, and `done` pulses once when the results are updated.

Top module: `restoring_divider`

## Requirements
- R1: After reset `busy`, `done`, `divByZero`, `quotient` and `remainder` are all 0.
- R2: With `isSigned`=0 the operands are unsigned, `quotient` is floor(dividend/divisor) and `remainder` is dividend − quotient×divisor, which is always less than the divisor.
- R3: With `isSigned`=1 the operands are two's complement. The quotient truncates toward zero, and its sign is the XOR of the operand signs (zero results carry no sign). The remainder takes the dividend's sign, quotient×divisor+remainder equals the dividend, and |remainder| < |divisor|.
- R4: In signed mode, the most negative value divided by −1 returns the most negative value as quotient (the magnitude wraps) with remainder 0.
- R5: For a non-zero divisor, `done` rises exactly WIDTH+2 cycles after the clock edge that accepts `start`, for one cycle. `busy` is high in every cycle between those two points.
- R6: `busy` and `done` are never high together. `quotient` and `remainder` change only in the cycle in which `done` is high.
- R7: A `start` while `busy` is high is ignored: the running operation keeps its operands, its results and its timing.
- R8: A zero divisor gives `done` one cycle after `start`, with `busy` staying low, `divByZero`=1, `quotient` all ones and `remainder` equal to the dividend bits. `divByZero` stays high until the next accepted `start` with a non-zero divisor, which clears it.
- R9: A dividend smaller in magnitude than the divisor, including a zero dividend, gives quotient 0 and remainder equal to the dividend.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division; taken only while not busy |
| isSigned | input | 1 | 1: two's complement operands, 0: unsigned |
| dividend | input | WIDTH | Dividend, sampled when start is taken |
| divisor | input | WIDTH | Divisor, sampled when start is taken |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when results are updated |
| divByZero | output | 1 | Last accepted request had a zero divisor |
| quotient | output | WIDTH | Quotient of the last finished request |
| remainder | output | WIDTH | Remainder of the last finished request |

## Verification
The unsigned cases include a dividend below the divisor, equal operands, a divisor of one and large values. Together they show whether every quotient bit is kept or discarded correctly, including the first trial step, which must always fail. The signed cases cover all four sign combinations with the same magnitudes, so a wrong quotient sign can be told apart from a wrong remainder sign, and the most negative value divided by −1 exposes magnitude wrap handling. Random operands in both modes are checked against the division identity and the remainder bound. A start pulse sent mid-operation, and zero divisors in both modes, separate the handshake and flag behaviour from the arithmetic.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

  typedef struct packed {
    logic load;      // accept operands, begin iterating
    logic zeroLoad;  // accept operands, divisor is zero
    logic step;      // one trial subtraction
    logic finish;    // apply signs, publish results
  } divStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } divState_t;

endpackage

// File: rtl/rdiv_ctrl.sv
module rdiv_ctrl
  import rdiv_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        divisorZero,
  output divStrobes_t strb,
  output logic        busy,
  output logic        done
);

  localparam int ITER = WIDTH + 1;
  localparam int CW   = $clog2(ITER + 1);

  divState_t      state;
  logic [CW-1:0]  count;

  always_comb begin
    strb = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (divisorZero) strb.zeroLoad = 1'b1;
          else             strb.load     = 1'b1;
        end
      end
      ST_RUN:  strb.step   = 1'b1;
      ST_FIN:  strb.finish = 1'b1;
      default: strb = '0;
    endcase
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      count <= '0;
      done  <= 1'b0;
    end else begin
      done <= strb.finish | strb.zeroLoad;
      unique case (state)
        ST_IDLE: begin
          if (strb.load) begin
            state <= ST_RUN;
            count <= '0;
          end
        end
        ST_RUN: begin
          count <= count + 1'b1;
          if (count == CW'(ITER - 1)) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: the done pulse only ever follows the busy window
  a_r6_busy_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R5: the finishing cycle is reached only after WIDTH+1 steps
  a_r5_full_iterations: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FIN) |-> (count == CW'(ITER)));

  // R7: a start during a run never drops the controller back to idle
  a_r7_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && start) |=> (state != ST_IDLE));

  // R5: an accepted non-zero request raises busy on the next cycle
  a_r5_start_launches: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load |=> busy);

endmodule

// File: rtl/rdiv_datapath.sv
module rdiv_datapath
  import rdiv_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  divStrobes_t      strb,
  input  logic             isSigned,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             divisorZero,
  output logic             divByZero,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);

  localparam int DW = 2 * WIDTH;

  logic             aNeg, bNeg;
  logic [WIDTH-1:0] aMag, bMag;
  logic [DW-1:0]    remReg;
  logic [DW-1:0]    dvsrReg;
  logic [WIDTH-1:0] quoReg;
  logic             negQ, negR;
  logic [DW:0]      diff;
  logic             takeIt;
  logic [WIDTH-1:0] remLow;

  // operand sign capture and magnitude conversion
  assign aNeg        = isSigned & dividend[WIDTH-1];
  assign bNeg        = isSigned & divisor[WIDTH-1];
  assign aMag        = aNeg ? (~dividend + 1'b1) : dividend;
  assign bMag        = bNeg ? (~divisor + 1'b1)  : divisor;
  assign divisorZero = (divisor == '0);

  // trial subtraction with one extra bit to expose the borrow
  assign diff   = {1'b0, remReg} - {1'b0, dvsrReg};
  assign takeIt = ~diff[DW];
  assign remLow = remReg[WIDTH-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remReg  <= '0;
      dvsrReg <= '0;
      quoReg  <= '0;
      negQ    <= 1'b0;
      negR    <= 1'b0;
    end else if (strb.load) begin
      remReg  <= {{WIDTH{1'b0}}, aMag};
      dvsrReg <= {bMag, {WIDTH{1'b0}}};
      quoReg  <= '0;
      negQ    <= aNeg ^ bNeg;
      negR    <= aNeg;
    end else if (strb.step) begin
      if (takeIt) remReg <= diff[DW-1:0];
      quoReg  <= {quoReg[WIDTH-2:0], takeIt};
      dvsrReg <= dvsrReg >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quotient  <= '0;
      remainder <= '0;
      divByZero <= 1'b0;
    end else if (strb.zeroLoad) begin
      quotient  <= '1;
      remainder <= dividend;
      divByZero <= 1'b1;
    end else if (strb.load) begin
      divByZero <= 1'b0;
    end else if (strb.finish) begin
      quotient  <= negQ ? (~quoReg + 1'b1) : quoReg;
      remainder <= negR ? (~remLow + 1'b1) : remLow;
    end
  end

  // R2: after every step the partial remainder is below the divisor it was tried against
  a_r2_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    strb.step |=> (remReg < $past(dvsrReg)));

  // R8: a zero divisor publishes the all-ones quotient and the raw dividend
  a_r8_zero_result: assert property (@(posedge clk) disable iff (!rst_n)
    strb.zeroLoad |=> (divByZero && (quotient == '1) && (remainder == $past(dividend))));

  // R6: results hold while the loop iterates
  a_r6_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
    strb.step |=> ($stable(quotient) && $stable(remainder)));

endmodule

// File: rtl/restoring_divider.sv
module restoring_divider
  import rdiv_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             isSigned,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic             divByZero,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);

  divStrobes_t strb;
  logic        divisorZero;

  rdiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .divisorZero (divisorZero),
    .strb        (strb),
    .busy        (busy),
    .done        (done)
  );

  rdiv_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .isSigned    (isSigned),
    .dividend    (dividend),
    .divisor     (divisor),
    .divisorZero (divisorZero),
    .divByZero   (divByZero),
    .quotient    (quotient),
    .remainder   (remainder)
  );

endmodule

// File: tb/restoring_divider_tb.sv
`timescale 1ns/1ps
module restoring_divider_tb;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         isSigned = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, divByZero;
  logic [W-1:0] quotient, remainder;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  restoring_divider #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .isSigned(isSigned),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .divByZero(divByZero), .quotient(quotient), .remainder(remainder)
  );

  // results captured by runDiv
  logic [W-1:0] gotQ, gotR;
  logic         gotDbz;
  int           gotLat;
  logic         busyOk;

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one request; lat = negedges after the accepting edge until done is seen
  task automatic runDiv(input logic [W-1:0] a, input logic [W-1:0] b, input logic sgn);
    @(negedge clk);
    dividend = a; divisor = b; isSigned = sgn; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    gotLat = 0;
    busyOk = 1'b1;
    while (!done && gotLat < 100) begin
      if (!busy) busyOk = 1'b0;
      @(negedge clk);
      gotLat++;
    end
    gotQ = quotient; gotR = remainder; gotDbz = divByZero;
  endtask

  task automatic testReset();
    check("R1", "busy", busy, 0);
    check("R1", "done", done, 0);
    check("R1", "divByZero", divByZero, 0);
    check("R1", "quotient", quotient, 0);
    check("R1", "remainder", remainder, 0);
  endtask

  task automatic unsignedCase(input int a, input int b, input string req);
    logic [W-1:0] eq, er;
    eq = W'(a / b);
    er = W'(a % b);
    runDiv(W'(a), W'(b), 1'b0);
    check(req, "unsigned quotient", gotQ, eq);
    check(req, "unsigned remainder", gotR, er);
    check("R5", "latency", gotLat, W + 2);
  endtask

  task automatic testUnsigned();
    unsignedCase(100, 7, "R2");
    unsignedCase(65535, 1, "R2");
    unsignedCase(65535, 65535, "R2");
    unsignedCase(40000, 255, "R2");
    unsignedCase(5, 9, "R9");
    unsignedCase(0, 3, "R9");
    // R5: busy throughout, single-cycle done, outputs held afterwards
    runDiv(16'd1000, 16'd3, 1'b0);
    check("R5", "busy window", busyOk, 1);
    check("R6", "busy with done", busy, 0);
    @(negedge clk);
    check("R5", "done width", done, 0);
    check("R6", "quotient held", quotient, 333);
    check("R6", "remainder held", remainder, 1);
  endtask

  task automatic signedCase(input int a, input int b, input string req);
    logic [W-1:0] eq, er;
    int q, r;
    q = a / b;
    r = a % b;
    eq = q[W-1:0];
    er = r[W-1:0];
    runDiv(W'(a), W'(b), 1'b1);
    check(req, "signed quotient", gotQ, eq);
    check(req, "signed remainder", gotR, er);
  endtask

  task automatic testSigned();
    signedCase(100, 7, "R3");
    signedCase(-100, 7, "R3");
    signedCase(100, -7, "R3");
    signedCase(-100, -7, "R3");
    signedCase(-32768, 3, "R3");
    signedCase(-5, 9, "R9");
    signedCase(32767, -32768, "R9");
    check("R5", "signed latency", gotLat, W + 2);
  endtask

  task automatic testMinByMinusOne();
    runDiv(16'h8000, 16'hFFFF, 1'b1);
    check("R4", "quotient wraps", gotQ, 16'h8000);
    check("R4", "remainder zero", gotR, 0);
    runDiv(16'h8000, 16'hFFFF, 1'b0);
    check("R2", "same bits unsigned quotient", gotQ, 0);
    check("R2", "same bits unsigned remainder", gotR, 16'h8000);
  endtask

  task automatic testDivZero();
    runDiv(16'd1234, 16'd0, 1'b0);
    check("R8", "latency", gotLat, 0);
    check("R8", "busy low", busy, 0);
    check("R8", "flag", gotDbz, 1);
    check("R8", "quotient ones", gotQ, 16'hFFFF);
    check("R8", "remainder dividend", gotR, 1234);
    @(negedge clk);
    check("R8", "flag holds", divByZero, 1);
    runDiv(16'hFF38, 16'd0, 1'b1);
    check("R8", "signed flag", gotDbz, 1);
    check("R8", "signed remainder bits", gotR, 16'hFF38);
    runDiv(16'd50, 16'd5, 1'b0);
    check("R8", "flag cleared", gotDbz, 0);
    check("R8", "next quotient", gotQ, 10);
  endtask

  task automatic testBusyIgnore();
    int lat;
    @(negedge clk);
    dividend = 16'd1000; divisor = 16'd7; isSigned = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    repeat (3) begin @(negedge clk); lat++; end
    dividend = 16'd1; divisor = 16'd0; start = 1'b1;
    @(negedge clk); lat++;
    dividend = 16'd9; divisor = 16'd2;
    @(negedge clk); lat++;
    start = 1'b0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    check("R7", "latency kept", lat, W + 2);
    check("R7", "quotient kept", quotient, 142);
    check("R7", "remainder kept", remainder, 6);
    check("R7", "no zero flag", divByZero, 0);
  endtask

  task automatic testRandom();
    int badU = 0, badS = 0;
    for (int i = 0; i < 150; i++) begin
      logic [W-1:0] a, b;
      a = W'($urandom);
      b = W'($urandom >> (i % 14));
      if (b == 0) b = 16'd1;
      runDiv(a, b, 1'b0);
      if (longint'(gotQ) * longint'(b) + longint'(gotR) != longint'(a) || gotR >= b) begin
        badU++;
        $display("FAIL R2 random %0d/%0d: actual q=%0d r=%0d expected q=%0d r=%0d",
                 a, b, gotQ, gotR, a / b, a % b);
      end
    end
    check("R2", "random unsigned mismatches", badU, 0);
    for (int i = 0; i < 150; i++) begin
      logic [W-1:0] a, b;
      int as, bs, qs, rs, ra, rb;
      a = W'($urandom);
      b = W'($urandom >> (i % 14));
      if (b == 0) b = 16'd3;
      if (a == 16'h8000 && b == 16'hFFFF) b = 16'd2;
      runDiv(a, b, 1'b1);
      as = int'($signed(a)); bs = int'($signed(b));
      qs = int'($signed(gotQ)); rs = int'($signed(gotR));
      ra = (rs < 0) ? -rs : rs;
      rb = (bs < 0) ? -bs : bs;
      if (qs * bs + rs != as || ra >= rb || (rs != 0 && ((rs < 0) != (as < 0)))) begin
        badS++;
        $display("FAIL R3 random %0d/%0d: actual q=%0d r=%0d expected q=%0d r=%0d",
                 as, bs, qs, rs, as / bs, as % bs);
      end
    end
    check("R3", "random signed mismatches", badS, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testUnsigned();
    testSigned();
    testMinByMinusOne();
    testDivZero();
    testBusyIgnore();
    testRandom();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule